// File: doc/BRIEF.md
# Mixed-Sign Integer Multiplier

This block forms the product of two integer operands in one combinational pass. Each operand can be read as signed or unsigned, and the two can differ. Every mode runs through one shared 17-by-17 signed multiply core. An operand marked signed copies its top bit into a seventeenth bit. An operand marked unsigned gets a zero there. The core therefore never needs a separate unsigned or mixed-sign variant.

The second operand can come from the 16-bit input bus or from a 5-bit literal field. The literal is always read as unsigned. A byte mode multiplies the low bytes of the two operands as unsigned values. The product is 32 bits wide. It is taken from the low bits of the 34-bit core result, and every supported mode fits there exactly.

There is no clock and no state. The result follows the inputs as soon as the logic settles.

Top module: `mixed_mult`

## Requirements
- R1: With both signedness selects high, the literal select low and byte mode low, `prod_o` is the 32-bit two's-complement product of `a_i` and `b_i`, both read as signed.
- R2: With both signedness selects low, the literal select low and byte mode low, `prod_o` is the unsigned product of `a_i` and `b_i`. The largest case, 0xFFFF times 0xFFFF, gives 0xFFFE0001.
- R3: With `a_signed_i` high, `b_signed_i` low, the literal select low and byte mode low, `prod_o` is signed `a_i` times unsigned `b_i`. For example, 0x8000 times 0xFFFF gives 0x80008000.
- R4: With `a_signed_i` low, `b_signed_i` high, the literal select low and byte mode low, `prod_o` is unsigned `a_i` times signed `b_i`.
- R5: With `lit_sel_i` high, the second operand is `lit_i`, zero-extended and read as unsigned. In that case `b_i` and `b_signed_i` have no effect on `prod_o`. `a_i` is still read according to `a_signed_i`.
- R6: With `byte_mode_i` high, only bits 7:0 of the first operand and of the selected second operand are used, both as unsigned. The upper bytes and both signedness selects have no effect, and `prod_o[31:16]` is zero.
- R7: The block is purely combinational. A change on any input appears on `prod_o` without any clock edge.
- R8: The 34-bit core result never loses information in the 32-bit output. When either effective operand is signed, core bits 33:32 repeat bit 31. When neither is signed, those two bits are zero. A zero operand gives a zero product.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 16 | First operand |
| b_i | input | 16 | Second operand from the bus |
| a_signed_i | input | 1 | First operand is read as two's complement |
| b_signed_i | input | 1 | Bus second operand is read as two's complement |
| lit_i | input | 5 | Unsigned literal second operand |
| lit_sel_i | input | 1 | Take the second operand from `lit_i` instead of `b_i` |
| byte_mode_i | input | 1 | Multiply the low bytes only, as unsigned values |
| prod_o | output | 32 | Product |

## Verification
The assertions are evaluated each time the inputs change. They check that byte-mode results stay within 16 bits and that the unsigned product matches plain unsigned arithmetic. They also check the sign of signed results, the bound on literal products, and that the two core bits dropped from the output are pure extension. The bench is the only place that shows the exact values of the mixed-sign and literal modes. It also shows that `b_i`, the upper bytes and the signedness selects are truly ignored when they should be, and that the output moves without a clock. It does this with hand-worked corner vectors and a sweep against independent reference arithmetic.

// File: rtl/mulx_pkg.sv
package mulx_pkg;
   // core architecture choice
   localparam int ARCH_NATIVE = 0;
   localparam int ARCH_ARRAY  = 1;

   typedef struct packed {
      logic a_sgn;
      logic b_sgn;
   } sign_sel_t;
endpackage

// File: rtl/mulx_opsel.sv
module mulx_opsel #(
   parameter int DATA_W = 16,
   parameter int LIT_W  = 5,
   parameter int BYTE_W = 8
) (
   input  logic [DATA_W-1:0]  a_i,
   input  logic [DATA_W-1:0]  b_i,
   input  logic [LIT_W-1:0]   lit_i,
   input  logic               a_signed_i,
   input  logic               b_signed_i,
   input  logic               lit_sel_i,
   input  logic               byte_mode_i,
   output logic [DATA_W-1:0]  a_o,
   output logic [DATA_W-1:0]  b_o,
   output mulx_pkg::sign_sel_t sgn_o
);
   localparam int LIT_PAD  = DATA_W - LIT_W;
   localparam int BYTE_PAD = DATA_W - BYTE_W;

   logic [DATA_W-1:0] b_src;

   // literal replaces the bus operand and is always unsigned
   assign b_src = lit_sel_i ? {{LIT_PAD{1'b0}}, lit_i} : b_i;

   always_comb begin
      if (byte_mode_i) begin
         a_o         = {{BYTE_PAD{1'b0}}, a_i[BYTE_W-1:0]};
         b_o         = {{BYTE_PAD{1'b0}}, b_src[BYTE_W-1:0]};
         sgn_o.a_sgn = 1'b0;
         sgn_o.b_sgn = 1'b0;
      end else begin
         a_o         = a_i;
         b_o         = b_src;
         sgn_o.a_sgn = a_signed_i;
         sgn_o.b_sgn = b_signed_i & ~lit_sel_i;
      end
   end
endmodule

// File: rtl/mulx_extend.sv
module mulx_extend #(
   parameter int IN_W  = 16,
   parameter int OUT_W = 17
) (
   input  logic [IN_W-1:0]  val_i,
   input  logic             signed_i,
   output logic [OUT_W-1:0] val_o
);
   localparam int PAD_W = OUT_W - IN_W;

   if (PAD_W < 1) begin : g_bad_width
      $error("mulx_extend: OUT_W must exceed IN_W");
   end

   logic fill;
   assign fill  = signed_i & val_i[IN_W-1];
   assign val_o = {{PAD_W{fill}}, val_i};
endmodule

// File: rtl/mulx_core.sv
module mulx_core #(
   parameter int W    = 17,
   parameter int ARCH = mulx_pkg::ARCH_NATIVE
) (
   input  logic [W-1:0]   x_i,
   input  logic [W-1:0]   y_i,
   output logic [2*W-1:0] p_o
);
   localparam int P = 2 * W;

   if (ARCH != mulx_pkg::ARCH_NATIVE && ARCH != mulx_pkg::ARCH_ARRAY) begin : g_bad_arch
      $error("mulx_core: unknown ARCH value");
   end

   if (ARCH == mulx_pkg::ARCH_NATIVE) begin : g_native
      logic signed [P-1:0] p_s;
      assign p_s = P'($signed(x_i)) * P'($signed(y_i));
      assign p_o = p_s;
   end else begin : g_array
      logic [P-1:0] xw;
      assign xw = {{W{x_i[W-1]}}, x_i};
      // two's-complement rows: the top multiplier bit has negative weight
      for (genvar i = 0; i < W; i++) begin : g_row
         logic [P-1:0] pp;
         logic [P-1:0] sum;
         assign pp = y_i[i] ? (xw << i) : '0;
         if (i == 0) begin : g_first
            assign sum = pp;
         end else if (i == W - 1) begin : g_last
            assign sum = g_row[i-1].sum - pp;
         end else begin : g_mid
            assign sum = g_row[i-1].sum + pp;
         end
      end
      assign p_o = g_row[W-1].sum;
   end

   always_comb begin
      if (x_i == '0 || y_i == '0) begin
         assert_core_zero_R8: assert (p_o == '0)
            else $error("core product of zero operand is nonzero");
      end
   end
endmodule

// File: rtl/mixed_mult.sv
module mixed_mult #(
   parameter int DATA_W    = 16,
   parameter int LIT_W     = 5,
   parameter int BYTE_W    = 8,
   parameter int CORE_ARCH = mulx_pkg::ARCH_NATIVE
) (
   input  logic [DATA_W-1:0]   a_i,
   input  logic [DATA_W-1:0]   b_i,
   input  logic                a_signed_i,
   input  logic                b_signed_i,
   input  logic [LIT_W-1:0]    lit_i,
   input  logic                lit_sel_i,
   input  logic                byte_mode_i,
   output logic [2*DATA_W-1:0] prod_o
);
   localparam int CORE_W = DATA_W + 1;
   localparam int PROD_W = 2 * DATA_W;
   localparam int FULL_W = 2 * CORE_W;

   if (DATA_W < 2) begin : g_bad_data
      $error("mixed_mult: DATA_W must be at least 2");
   end
   if (LIT_W < 1 || LIT_W >= DATA_W) begin : g_bad_lit
      $error("mixed_mult: LIT_W must lie in 1..DATA_W-1");
   end
   if (BYTE_W < 1 || BYTE_W >= DATA_W) begin : g_bad_byte
      $error("mixed_mult: BYTE_W must lie in 1..DATA_W-1");
   end

   logic [DATA_W-1:0]   a_sel, b_sel;
   mulx_pkg::sign_sel_t sgn;
   logic [CORE_W-1:0]   a_ext, b_ext;
   logic [FULL_W-1:0]   full_p;

   mulx_opsel #(.DATA_W(DATA_W), .LIT_W(LIT_W), .BYTE_W(BYTE_W)) u_opsel (
      .a_i        (a_i),
      .b_i        (b_i),
      .lit_i      (lit_i),
      .a_signed_i (a_signed_i),
      .b_signed_i (b_signed_i),
      .lit_sel_i  (lit_sel_i),
      .byte_mode_i(byte_mode_i),
      .a_o        (a_sel),
      .b_o        (b_sel),
      .sgn_o      (sgn)
   );

   mulx_extend #(.IN_W(DATA_W), .OUT_W(CORE_W)) u_ext_a (
      .val_i   (a_sel),
      .signed_i(sgn.a_sgn),
      .val_o   (a_ext)
   );

   mulx_extend #(.IN_W(DATA_W), .OUT_W(CORE_W)) u_ext_b (
      .val_i   (b_sel),
      .signed_i(sgn.b_sgn),
      .val_o   (b_ext)
   );

   mulx_core #(.W(CORE_W), .ARCH(CORE_ARCH)) u_core (
      .x_i(a_ext),
      .y_i(b_ext),
      .p_o(full_p)
   );

   assign prod_o = full_p[PROD_W-1:0];

   // checks beside the datapath
   always_comb begin
      if (byte_mode_i) begin
         assert_byte_upper_zero_R6: assert (prod_o[PROD_W-1:2*BYTE_W] == '0)
            else $error("byte mode product exceeds byte-squared range");
      end
      if (!byte_mode_i && !lit_sel_i && !a_signed_i && !b_signed_i) begin
         assert_unsigned_match_R2: assert (prod_o ==
               {{DATA_W{1'b0}}, a_i} * {{DATA_W{1'b0}}, b_i})
            else $error("unsigned product mismatch");
      end
      if (!byte_mode_i && !lit_sel_i && a_signed_i && b_signed_i
          && a_i != '0 && b_i != '0) begin
         assert_signed_sign_R1: assert (prod_o[PROD_W-1] == (a_i[DATA_W-1] ^ b_i[DATA_W-1]))
            else $error("signed product has wrong sign");
      end
      if (lit_sel_i && !byte_mode_i && !a_signed_i) begin
         assert_lit_bound_R5: assert (prod_o < ({{DATA_W{1'b0}}, a_i} << LIT_W) + 1)
            else $error("literal product out of range");
      end
      if (a_signed_i && !byte_mode_i || b_signed_i && !byte_mode_i && !lit_sel_i) begin
         assert_ext_signed_R8: assert (full_p[FULL_W-1:PROD_W] == {(FULL_W-PROD_W){full_p[PROD_W-1]}})
            else $error("signed product overflowed output width");
      end else begin
         assert_ext_unsigned_R8: assert (full_p[FULL_W-1:PROD_W] == '0)
            else $error("unsigned product overflowed output width");
      end
   end
endmodule

// File: tb/mixed_mult_tb.sv
module mixed_mult_tb;
   localparam int CLK_PERIOD = 10;
   localparam int NVEC = 15;

   logic        clk = 1'b0;
   logic [15:0] a, b;
   logic        as_, bs_, ls, bm;
   logic [4:0]  lit;
   logic [31:0] prod;
   int          checks = 0;
   int          fails  = 0;
   bit          done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   mixed_mult u_dut (
      .a_i(a), .b_i(b), .a_signed_i(as_), .b_signed_i(bs_),
      .lit_i(lit), .lit_sel_i(ls), .byte_mode_i(bm), .prod_o(prod)
   );

   // {a, b, lit, a_signed, b_signed, lit_sel, byte_mode, expected}
   localparam logic [72:0] VEC [NVEC] = '{
      {16'hFFFF, 16'hFFFF, 5'd0,  4'b1100, 32'h0000_0001}, // R1
      {16'h8000, 16'h8000, 5'd0,  4'b1100, 32'h4000_0000}, // R1
      {16'h7FFF, 16'h8000, 5'd0,  4'b1100, 32'hC000_8000}, // R1
      {16'hFFFF, 16'hFFFF, 5'd0,  4'b0000, 32'hFFFE_0001}, // R2
      {16'h8000, 16'h0002, 5'd0,  4'b0000, 32'h0001_0000}, // R2
      {16'hFFFF, 16'hFFFF, 5'd0,  4'b1000, 32'hFFFF_0001}, // R3
      {16'h8000, 16'hFFFF, 5'd0,  4'b1000, 32'h8000_8000}, // R3
      {16'hFFFF, 16'h8000, 5'd0,  4'b0100, 32'h8000_8000}, // R4
      {16'h0003, 16'hFFFE, 5'd0,  4'b0100, 32'hFFFF_FFFA}, // R4
      {16'hFFF0, 16'hFFFF, 5'd31, 4'b1110, 32'hFFFF_FE10}, // R5
      {16'hFFFF, 16'h8000, 5'd31, 4'b0110, 32'h001E_FFE1}, // R5
      {16'h1234, 16'hFFFF, 5'd0,  4'b1110, 32'h0000_0000}, // R5
      {16'hABFF, 16'h12FF, 5'd0,  4'b1101, 32'h0000_FE01}, // R6
      {16'h8080, 16'h7F02, 5'd0,  4'b1001, 32'h0000_0100}, // R6
      {16'h0000, 16'h8000, 5'd0,  4'b1100, 32'h0000_0000}  // R8
   };

   function automatic logic [31:0] ref_mul(input logic [15:0] ra, input logic [15:0] rb,
                                           input logic [4:0] rl, input logic sa,
                                           input logic sb, input logic sl, input logic sm);
      logic [15:0] bb;
      longint va, vb, r;
      bb = sl ? {11'd0, rl} : rb;
      if (sm) begin
         va = longint'(ra[7:0]);
         vb = longint'(bb[7:0]);
      end else begin
         va = sa ? longint'($signed(ra)) : longint'(ra);
         vb = (sb && !sl) ? longint'($signed(bb)) : longint'(bb);
      end
      r = va * vb;
      return r[31:0];
   endfunction

   task automatic apply(input logic [15:0] ta, input logic [15:0] tb_,
                        input logic [4:0] tl, input logic [3:0] mode);
      @(negedge clk);
      a = ta; b = tb_; lit = tl;
      {as_, bs_, ls, bm} = mode;
      #(CLK_PERIOD/4);
   endtask

   task automatic check(input string req, input logic [31:0] exp);
      checks++;
      if (prod !== exp) begin
         fails++;
         $display("FAIL %s: got %h expected %h (a=%h b=%h lit=%0d mode=%b)",
                  req, prod, exp, a, b, lit, {as_, bs_, ls, bm});
      end
   endtask

   initial begin
      a = '0; b = '0; lit = '0; as_ = 0; bs_ = 0; ls = 0; bm = 0;
      #(CLK_PERIOD/4);
      check("R7 idle", 32'h0);

      for (int i = 0; i < NVEC; i++) begin
         apply(VEC[i][72:57], VEC[i][56:41], VEC[i][40:36], VEC[i][35:32]);
         check("R1-R8 table", VEC[i][31:0]);
      end

      // R5: bus operand and its signedness ignored when literal selected
      apply(16'h0100, 16'h0000, 5'd7, 4'b0010);
      check("R5 b_i=0", 32'h0000_0700);
      apply(16'h0100, 16'hFFFF, 5'd7, 4'b0110);
      check("R5 b_i=FFFF signed", 32'h0000_0700);

      // R6: upper bytes and signedness ignored in byte mode
      apply(16'h00FF, 16'h0080, 5'd0, 4'b0001);
      check("R6 base", 32'h0000_7F80);
      apply(16'hFFFF, 16'hFF80, 5'd0, 4'b1101);
      check("R6 upper set", 32'h0000_7F80);
      apply(16'h00FF, 16'hFFFF, 5'd3, 4'b1011);
      check("R6 literal", 32'h0000_02FD);

      // R7: output follows an input change with no clock edge
      apply(16'h0010, 16'h0010, 5'd0, 4'b0000);
      a = 16'h0020;
      #1;
      check("R7 no clock", 32'h0000_0200);

      // sweep against reference arithmetic in every mode
      for (int i = 0; i < 1600; i++) begin
         logic [31:0] r1, r2;
         logic [3:0]  md;
         r1 = $urandom;
         r2 = $urandom;
         md = 4'(i % 16);
         apply(r1[15:0], r1[31:16], r2[4:0], md);
         check("R1-R6 sweep", ref_mul(a, b, lit, as_, bs_, ls, bm));
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end
endmodule